// File: doc/BRIEF.md
# Short Vector Register Address Sequencer

A short-vector floating-point instruction names one destination register and two source registers. A length field and a stride field turn that instruction into several iterations. This sequencer takes the starting register numbers and both fields when a start pulse arrives while it is idle. It then produces one iteration's register numbers per cycle, one iteration for each cycle the vector spends in the first execute stage.

Each register number has two parts: bank bits at the top and an index of three bits at the bottom. Each step adds the stride to the index only. The index wraps inside its bank of eight registers, and the bank bits never change.

With every issued iteration the block drives two masks for the register scoreboard. One is a lock request for that iteration's destination. The other is a release request for that iteration's two sources. Because sources are freed iteration by iteration, a following instruction can use early-iteration registers before the vector finishes.

Top module: `svas_seq`

## Requirements
- R1: While `rst_n` is low, `idle_o` is 1, `valid_o` and `last_o` are 0, and both masks are all zero; asserting reset during a run ends the run at once.
- R2: A start pulse sampled while `idle_o` is 1 makes `valid_o` rise on the next cycle, with `dst_o`, `srca_o` and `srcb_o` equal to the three base inputs.
- R3: The length field holds the iteration count minus one, so a field of N gives N+1 iterations; `last_o` is 1 only together with the final iteration.
- R4: From one iteration to the next, bits [2:0] of each register number grow by the stride field plus one, modulo 8, and bits [4:3] are kept.
- R5: Index wrap: a vector with base 7 and stride field 0 uses registers 7, 0, 1, 2.
- R6: Iterations appear on consecutive cycles with no gap; the cycle after `last_o`, `valid_o` is 0 and `idle_o` is 1.
- R7: A start pulse while not idle is ignored: the running sequence is unchanged and no new sequence follows it.
- R8: A length field of 0 (scalar) produces exactly one iteration, with `last_o` set.
- R9: While `valid_o` is 1, `rel_src_o` has exactly the bits numbered `srca_o` and `srcb_o` set; otherwise it is zero.
- R10: While `valid_o` is 1, `lock_dst_o` has only bit `dst_o` set; otherwise it is zero.
- R11: The length and stride fields are captured at the accepted start; later changes to them do not alter a running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| dst_base_i | input | 5 | First destination register number |
| srca_base_i | input | 5 | First source A register number |
| srcb_base_i | input | 5 | First source B register number |
| len_i | input | 3 | Iteration count minus one |
| stride_i | input | 2 | Register step minus one |
| idle_o | output | 1 | Sequencer ready for a start |
| valid_o | output | 1 | An iteration is issued this cycle |
| last_o | output | 1 | Final iteration of the vector |
| dst_o | output | 5 | Destination register of this iteration |
| srca_o | output | 5 | Source A register of this iteration |
| srcb_o | output | 5 | Source B register of this iteration |
| lock_dst_o | output | 32 | Lock request mask for the destination |
| rel_src_o | output | 32 | Release request mask for the sources |

## Verification
The properties assume that the length and stride inputs are stable in the cycle a start pulse is taken. They also assume that base register numbers may wrap anywhere in their bank. They put no condition on `start_i` while busy, because ignoring it is itself a property.

The stimulus drives every input half a cycle away from the active edge. Some runs start at index 7 or use the largest stride, so that the wrap path is exercised. One run deliberately raises `start_i` and changes both fields while busy, and it lowers the pulse on the final iteration so that the following idle cycle stays clean.

// File: rtl/svas_pkg.sv
package svas_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/svas_addr_step.sv
// One operand's register number: loaded from a base, then stepped
// inside its bank, with the bank bits held.
module svas_addr_step #(
  parameter int REG_W = 5,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic [REG_W-1:0] base_i,
  input  logic [IDX_W-1:0] step_i,
  output logic [REG_W-1:0] addr_o
);
  localparam int BANK_W = REG_W - IDX_W;

  logic [REG_W-1:0] addr_q, addr_d;
  logic             addr_en;
  logic [IDX_W-1:0] idx_next;

  always_comb begin
    idx_next = addr_q[IDX_W-1:0] + step_i;
    addr_en  = load_i | adv_i;
    if (load_i) addr_d = base_i;
    else        addr_d = {addr_q[REG_W-1:IDX_W], idx_next};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr_o = addr_q;

  // R4: bank bits survive a step
  p_bank_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i) |=> (addr_o[REG_W-1:IDX_W] == $past(addr_o[REG_W-1:IDX_W])));

  initial begin
    if (BANK_W < 1) $error("svas_addr_step: REG_W must exceed IDX_W");
  end
endmodule

// File: rtl/svas_iter_ctrl.sv
// Iteration counter and run state.
module svas_iter_ctrl #(
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             idle_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             load_o,
  output logic             adv_o
);
  import svas_pkg::*;

  seq_state_e       state_q, state_d;
  logic [LEN_W-1:0] cnt_q, cnt_d, len_q;
  logic             cnt_en;

  always_comb begin
    idle_o  = (state_q == SEQ_IDLE);
    valid_o = (state_q == SEQ_RUN);
    last_o  = valid_o && (cnt_q == len_q);
    load_o  = idle_o && start_i;
    adv_o   = valid_o && !last_o;
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = load_o | adv_o;
    if (load_o) begin
      state_d = SEQ_RUN;
      cnt_d   = '0;
    end else if (adv_o) begin
      cnt_d   = cnt_q + LEN_W'(1);
    end else if (last_o) begin
      state_d = SEQ_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (load_o) len_q <= len_i;
  end

  // R6: no gap inside a vector
  p_no_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !last_o) |=> valid_o);
  // R6: idle right after the final iteration
  p_last_then_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && last_o) |=> (idle_o && !valid_o));
  // R3: last only with a valid iteration
  p_last_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);
  // R8: scalar start yields a single final iteration
  p_scalar_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && idle_o && (len_i == '0)) |=> (valid_o && last_o));
  // R11: captured length held through a run
  p_len_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !last_o) |=> $stable(len_q));
endmodule

// File: rtl/svas_reg_mask.sv
// Decodes a set of register numbers into one bit mask, gated by enable.
module svas_reg_mask #(
  parameter int REG_W = 5,
  parameter int N_IN  = 2
) (
  input  logic                       en_i,
  input  logic [N_IN-1:0][REG_W-1:0] addr_i,
  output logic [(1<<REG_W)-1:0]      mask_o
);
  localparam int NREG = 1 << REG_W;

  logic [N_IN-1:0][NREG-1:0] onehot;

  for (genvar g = 0; g < N_IN; g++) begin : g_dec
    assign onehot[g] = en_i ? (NREG'(1) << addr_i[g]) : '0;
  end

  always_comb begin
    mask_o = '0;
    for (int i = 0; i < N_IN; i++) mask_o = mask_o | onehot[i];
  end

  // R9/R10: a mask is empty when disabled and holds 1..N_IN bits when enabled
  always_comb begin
    if (!en_i) a_mask_empty_r9: assert (mask_o == '0);
    else       a_mask_count_r10: assert (($countones(mask_o) >= 1) && ($countones(mask_o) <= N_IN));
  end
endmodule

// File: rtl/svas_seq.sv
module svas_seq #(
  parameter int REG_W    = 5,
  parameter int IDX_W    = 3,
  parameter int LEN_W    = 3,
  parameter int STRIDE_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [REG_W-1:0]      dst_base_i,
  input  logic [REG_W-1:0]      srca_base_i,
  input  logic [REG_W-1:0]      srcb_base_i,
  input  logic [LEN_W-1:0]      len_i,
  input  logic [STRIDE_W-1:0]   stride_i,
  output logic                  idle_o,
  output logic                  valid_o,
  output logic                  last_o,
  output logic [REG_W-1:0]      dst_o,
  output logic [REG_W-1:0]      srca_o,
  output logic [REG_W-1:0]      srcb_o,
  output logic [(1<<REG_W)-1:0] lock_dst_o,
  output logic [(1<<REG_W)-1:0] rel_src_o
);
  localparam int NREG  = 1 << REG_W;
  localparam int N_OPS = 3;

  logic                        load, adv;
  logic [STRIDE_W-1:0]         stride_q;
  logic [IDX_W-1:0]            step;
  logic [N_OPS-1:0][REG_W-1:0] bases, addrs;

  svas_iter_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .len_i   (len_i),
    .idle_o  (idle_o),
    .valid_o (valid_o),
    .last_o  (last_o),
    .load_o  (load),
    .adv_o   (adv)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    stride_q <= '0;
    else if (load) stride_q <= stride_i;
  end

  assign step  = IDX_W'(stride_q) + IDX_W'(1);
  assign bases = {srcb_base_i, srca_base_i, dst_base_i};

  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    svas_addr_step #(.REG_W(REG_W), .IDX_W(IDX_W)) u_step (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .adv_i  (adv),
      .base_i (bases[g]),
      .step_i (step),
      .addr_o (addrs[g])
    );
  end

  assign dst_o  = addrs[0];
  assign srca_o = addrs[1];
  assign srcb_o = addrs[2];

  svas_reg_mask #(.REG_W(REG_W), .N_IN(1)) u_lock (
    .en_i   (valid_o),
    .addr_i (addrs[0:0]),
    .mask_o (lock_dst_o)
  );

  svas_reg_mask #(.REG_W(REG_W), .N_IN(2)) u_rel (
    .en_i   (valid_o),
    .addr_i (addrs[2:1]),
    .mask_o (rel_src_o)
  );

  // R2: first iteration carries the bases
  p_first_iter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && idle_o) |=> (valid_o && (dst_o == $past(dst_base_i))
                             && (srca_o == $past(srca_base_i))));
  // R10: lock covers the current destination only
  p_lock_dst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ($onehot0(lock_dst_o) && lock_dst_o[dst_o]));
  // R9: release covers both current sources
  p_release_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (rel_src_o[srca_o] && rel_src_o[srcb_o]));
  // R7: a busy start leaves the destination stepping unchanged
  p_busy_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && valid_o && !last_o) |=> (dst_o[REG_W-1:IDX_W] == $past(dst_o[REG_W-1:IDX_W])));
  // R1: masks empty in idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> (!valid_o && (rel_src_o == '0) && (lock_dst_o == '0)));

  initial begin
    if (NREG > 1024) $error("svas_seq: register file too wide");
  end
endmodule

// File: tb/svas_seq_tb.sv
`timescale 1ns/1ps
module svas_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [4:0]  dst_base_i, srca_base_i, srcb_base_i;
  logic [2:0]  len_i;
  logic [1:0]  stride_i;
  logic        idle_o, valid_o, last_o;
  logic [4:0]  dst_o, srca_o, srcb_o;
  logic [31:0] lock_dst_o, rel_src_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  svas_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .dst_base_i(dst_base_i), .srca_base_i(srca_base_i), .srcb_base_i(srcb_base_i),
    .len_i(len_i), .stride_i(stride_i),
    .idle_o(idle_o), .valid_o(valid_o), .last_o(last_o),
    .dst_o(dst_o), .srca_o(srca_o), .srcb_o(srcb_o),
    .lock_dst_o(lock_dst_o), .rel_src_o(rel_src_o)
  );

  typedef struct packed {
    logic [4:0] d;
    logic [4:0] a;
    logic [4:0] b;
    logic [2:0] len;
    logic [1:0] str;
    logic [4:0] dlast;
  } vec_t;

  localparam vec_t TBL [5] = '{
    '{5'd8,  5'd7,  5'd16, 3'd3, 2'd0, 5'd11},
    '{5'd13, 5'd23, 5'd2,  3'd2, 2'd1, 5'd9},
    '{5'd31, 5'd30, 5'd29, 3'd0, 2'd2, 5'd31},
    '{5'd0,  5'd4,  5'd27, 3'd7, 2'd3, 5'd4},
    '{5'd18, 5'd12, 5'd1,  3'd4, 2'd2, 5'd22}
  };

  // R4: index grows by (stride field + 1) per iteration, modulo 8; bank kept
  function automatic logic [4:0] exp_addr(logic [4:0] base, int k, logic [1:0] str);
    logic [2:0] lo;
    lo = base[2:0] + 3'((k * (int'(str) + 1)) % 8);
    return {base[4:3], lo};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive_start(input logic [4:0] d, a, b, input logic [2:0] l, input logic [1:0] s);
    @(negedge clk);
    start_i = 1'b1; dst_base_i = d; srca_base_i = a; srcb_base_i = b;
    len_i = l; stride_i = s;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] m;
    rst_n = 1'b0; start_i = 1'b0;
    dst_base_i = '0; srca_base_i = '0; srcb_base_i = '0; len_i = '0; stride_i = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(idle_o && !valid_o && !last_o, "R1", {idle_o, valid_o, last_o}, 3'b100);
    chk((lock_dst_o == 0) && (rel_src_o == 0), "R1", lock_dst_o | rel_src_o, 0);
    rst_n = 1'b1;

    // Table walk
    for (int i = 0; i < 5; i++) begin
      drive_start(TBL[i].d, TBL[i].a, TBL[i].b, TBL[i].len, TBL[i].str);
      for (int k = 0; k <= int'(TBL[i].len); k++) begin
        chk(valid_o, (k == 0) ? "R2" : "R6", valid_o, 1);
        chk((dst_o == exp_addr(TBL[i].d, k, TBL[i].str)) &&
            (srca_o == exp_addr(TBL[i].a, k, TBL[i].str)) &&
            (srcb_o == exp_addr(TBL[i].b, k, TBL[i].str)),
            (k == 0) ? "R2" : "R4",
            {dst_o, srca_o, srcb_o},
            {exp_addr(TBL[i].d, k, TBL[i].str), exp_addr(TBL[i].a, k, TBL[i].str),
             exp_addr(TBL[i].b, k, TBL[i].str)});
        chk(last_o == (k == int'(TBL[i].len)), "R3", last_o, (k == int'(TBL[i].len)));
        if (i == 0 && k == 1) chk(srca_o == 5'd0, "R5", srca_o, 0);
        if (TBL[i].len == 0) chk(last_o, "R8", last_o, 1);
        if (k == int'(TBL[i].len)) chk(dst_o == TBL[i].dlast, "R4", dst_o, TBL[i].dlast);
        m = (32'd1 << exp_addr(TBL[i].a, k, TBL[i].str)) | (32'd1 << exp_addr(TBL[i].b, k, TBL[i].str));
        chk(rel_src_o == m, "R9", rel_src_o, m);
        m = 32'd1 << exp_addr(TBL[i].d, k, TBL[i].str);
        chk(lock_dst_o == m, "R10", lock_dst_o, m);
        @(negedge clk);
      end
      chk(!valid_o && idle_o, "R6", {valid_o, idle_o}, 2'b01);
      chk((rel_src_o == 0) && (lock_dst_o == 0), "R9", rel_src_o | lock_dst_o, 0);
    end

    // R7/R11: start and new fields while busy
    drive_start(5'd0, 5'd0, 5'd0, 3'd1, 2'd0);
    chk(valid_o && dst_o == 5'd0 && !last_o, "R2", {valid_o, dst_o}, 6'b1_00000);
    start_i = 1'b1; dst_base_i = 5'd20; srca_base_i = 5'd20; srcb_base_i = 5'd20;
    len_i = 3'd7; stride_i = 2'd3;
    @(negedge clk);
    start_i = 1'b0;
    chk(valid_o && last_o && dst_o == 5'd1, "R11", {valid_o, last_o, dst_o}, 7'b11_00001);
    @(negedge clk);
    chk(!valid_o && idle_o, "R7", {valid_o, idle_o}, 2'b01);
    @(negedge clk);
    chk(!valid_o && idle_o, "R7", {valid_o, idle_o}, 2'b01);

    // R1: reset during a run
    drive_start(5'd3, 5'd4, 5'd5, 3'd6, 2'd0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!valid_o && idle_o && (lock_dst_o == 0), "R1", {valid_o, idle_o}, 2'b01);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!valid_o && idle_o, "R1", {valid_o, idle_o}, 2'b01);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule